// File: doc/BRIEF.md
# UART Baud Rate Generator

This block derives the timing pulses a UART needs from its input clock. A 16-bit divisor, loaded through a one-cycle write strobe, sets the length of a free-running count: every divisor+1 enabled clock cycles the block emits a one-cycle sample tick. A second counter divides the sample ticks into bit times and emits a one-cycle baud tick on the sample tick that closes each bit. The transmit and receive shift logic use these ticks.

A rate-select input picks the sampling ratio. Low selects 16 sample ticks per bit, so baud = Fclk/(16·(divisor+1)). High selects 4 sample ticks per bit, so baud = Fclk/(4·(divisor+1)). A divisor write resets both counters, so the new rate starts at once and never waits for the old period to run out. For example, a divisor of 48 at 7.5 MHz in 16x mode gives about 9566 baud, which is 0.35 % below 9600.

Top module: `baud_gen`

## Requirements
- R1: `div_we` high at a rising edge loads `div_wdata` into the 16-bit divisor. Reset sets the divisor to 0.
- R2: While `en` is high and no write occurs, `sample_tick` is a one-cycle pulse that repeats every divisor+1 clock cycles. The first pulse follows the write, the reset release or the enable edge by divisor+1 cycles.
- R3: With `fast_mode` = 0, `baud_tick` pulses on every 16th sample tick and falls in the same cycle as that sample tick.
- R4: With `fast_mode` = 1, `baud_tick` pulses on every 4th sample tick and falls in the same cycle as that sample tick.
- R5: A divisor of 0 gives a sample tick on every cycle. A divisor of 65535 gives one sample tick per 65536 cycles. A divisor of 48 in 16x mode gives one baud tick per 784 cycles.
- R6: A divisor write clears the timer and the bit counter. No tick is produced in the cycle after the write, and counting restarts from zero.
- R7: A change of `fast_mode` clears the bit counter. No baud tick occurs in the cycle after the change, and the next bit lasts a full 16 or 4 sample ticks in the new mode.
- R8: While `en` is low, both counters stay at zero and neither tick is produced.
- R9: `rst` is synchronous and active high. It clears both counters, both ticks and the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables counting |
| fast_mode | input | 1 | 0: 16 sample ticks per bit, 1: 4 sample ticks per bit |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | New divisor value |
| sample_tick | output | 1 | Registered one-cycle sample pulse |
| baud_tick | output | 1 | Registered one-cycle bit pulse |

## Verification
The main function is tried with several divisors. A divisor of 0 separates a true every-cycle tick from an off-by-one period. Small divisors such as 2 expose errors in the period and in the 16-to-1 and 4-to-1 grouping within a few hundred cycles. The divisor 48 confirms the 784-cycle bit time. The divisor 65535 shows that the full 16-bit range is reached without wraparound.

Writes that land in the middle of a period check that the counters restart instead of finishing the old count. Mode flips in the middle of a bit check that the bit counter is cleared. Windows with `en` low and a reset during a run check that the block stays quiet and then starts cleanly.

// File: rtl/ubrg_pkg.sv
package ubrg_pkg;
  localparam int DIV_W     = 16;
  localparam int SLOW_RATIO = 16;
  localparam int FAST_RATIO = 4;
  typedef enum logic {OSR_SLOW = 1'b0, OSR_FAST = 1'b1} osr_mode_e;
endpackage

// File: rtl/ubrg_divreg.sv
module ubrg_divreg #(
  parameter int W = ubrg_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] div_o
);
  always_ff @(posedge clk) begin
    if (rst)     div_o <= '0;
    else if (we) div_o <= wdata;
  end

  // R9 / R1: reset leaves the divisor at zero
  a_r9_div_reset: assert property (@(posedge clk) rst |=> (div_o == '0));
  // R1: a write loads the written value
  a_r1_div_load: assert property (@(posedge clk) disable iff (rst)
    we |=> (div_o == $past(wdata)));
endmodule

// File: rtl/ubrg_timer.sv
module ubrg_timer #(
  parameter int W = ubrg_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] div_i,
  output logic         hit_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         run;

  assign run   = en && !clr;
  assign hit_o = run && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || !run)         cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= hit_o;
  end

  // R2: the running count never passes the divisor
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_i);
  // R6: a divisor write restarts the count
  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0) && !tick_o);
  // R8: disabled means idle
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0) && !tick_o);
endmodule

// File: rtl/ubrg_bitdiv.sv
module ubrg_bitdiv #(
  parameter int SLOW = ubrg_pkg::SLOW_RATIO,
  parameter int FAST = ubrg_pkg::FAST_RATIO
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  ubrg_pkg::osr_mode_e mode,
  input  logic hit_i,
  output logic bit_tick_o
);
  localparam int MAXR  = (SLOW > FAST) ? SLOW : FAST;
  localparam int SUB_W = (MAXR > 2) ? $clog2(MAXR) : 1;
  localparam logic [SUB_W-1:0] LIM_S = SUB_W'(SLOW - 1);
  localparam logic [SUB_W-1:0] LIM_F = SUB_W'(FAST - 1);

  logic [SUB_W-1:0]    sub_q;
  logic [SUB_W-1:0]    lim;
  ubrg_pkg::osr_mode_e mode_q;
  logic                mode_chg;
  logic                wrap;

  assign lim      = (mode == ubrg_pkg::OSR_FAST) ? LIM_F : LIM_S;
  assign mode_chg = (mode != mode_q);
  assign wrap     = (sub_q == lim);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= ubrg_pkg::OSR_SLOW;
    else     mode_q <= mode;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !en || mode_chg) begin
      sub_q      <= '0;
      bit_tick_o <= 1'b0;
    end else if (hit_i) begin
      sub_q      <= wrap ? '0 : sub_q + 1'b1;
      bit_tick_o <= wrap;
    end else begin
      bit_tick_o <= 1'b0;
    end
  end

  // R3 / R4: bit counter stays within the selected ratio
  a_r4_sub_bound: assert property (@(posedge clk) disable iff (rst)
    !mode_chg |-> (sub_q <= lim));
  // R7: a mode change suppresses the next bit tick
  a_r7_mode_clear: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !bit_tick_o && (sub_q == '0));
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int DIV_W = ubrg_pkg::DIV_W,
  parameter int SLOW  = ubrg_pkg::SLOW_RATIO,
  parameter int FAST  = ubrg_pkg::FAST_RATIO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fast_mode,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             sample_tick,
  output logic             baud_tick
);
  logic [DIV_W-1:0]    div_q;
  logic                hit;
  ubrg_pkg::osr_mode_e mode;

  assign mode = fast_mode ? ubrg_pkg::OSR_FAST : ubrg_pkg::OSR_SLOW;

  ubrg_divreg #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .we(div_we), .wdata(div_wdata), .div_o(div_q)
  );

  ubrg_timer #(.W(DIV_W)) u_tmr (
    .clk(clk), .rst(rst), .en(en), .clr(div_we), .div_i(div_q),
    .hit_o(hit), .tick_o(sample_tick)
  );

  ubrg_bitdiv #(.SLOW(SLOW), .FAST(FAST)) u_bit (
    .clk(clk), .rst(rst), .en(en), .clr(div_we), .mode(mode),
    .hit_i(hit), .bit_tick_o(baud_tick)
  );

  // R3 / R4: a bit tick always coincides with a sample tick
  a_r3_bit_on_sample: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> sample_tick);
  // R9: reset silences both outputs
  a_r9_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !sample_tick && !baud_tick);
endmodule

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        fast_mode = 1'b0;
  logic        div_we = 1'b0;
  logic [15:0] div_wdata = '0;
  logic        sample_tick, baud_tick;

  always #5 clk = ~clk;

  baud_gen dut (
    .clk(clk), .rst(rst), .en(en), .fast_mode(fast_mode),
    .div_we(div_we), .div_wdata(div_wdata),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string req = "R9";
  bit    done = 1'b0;
  int    st_count = 0;
  int    bt_count = 0;

  // behavioural reference
  int m_div = 0, m_cnt = 0, m_sub = 0, m_mode = 0;
  bit m_st = 0, m_bt = 0;

  always @(posedge clk) begin
    int per;
    per = fast_mode ? 4 : 16;
    if (rst) begin
      m_div = 0; m_cnt = 0; m_sub = 0; m_st = 0; m_bt = 0; m_mode = 0;
    end else begin
      if (div_we || !en) begin
        if (div_we) m_div = div_wdata;
        m_cnt = 0; m_sub = 0; m_st = 0; m_bt = 0;
      end else begin
        m_st = (m_cnt == m_div);
        m_cnt = m_st ? 0 : m_cnt + 1;
        if (m_mode != int'(fast_mode)) begin
          m_sub = 0; m_bt = 0;
        end else if (m_st) begin
          m_bt = (m_sub == per - 1);
          m_sub = m_bt ? 0 : m_sub + 1;
        end else m_bt = 0;
      end
      m_mode = int'(fast_mode);
    end
  end

  task automatic check(string r, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %0d expected %0d at %0t", r, what, got, exp, $time);
    end
  endtask

  // one cycle: compare at the falling edge, then allow new inputs
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, "sample_tick", sample_tick, m_st);
      check(req, "baud_tick", baud_tick, m_bt);
      st_count += sample_tick;
      bt_count += baud_tick;
      div_we = 1'b0;
    end
  endtask

  task automatic write_div(int v);
    div_we = 1'b1; div_wdata = 16'(v);
    step(1);
  endtask

  initial begin
    #1900000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    req = "R9"; step(3);
    check("R9", "reset sample_tick", sample_tick, 0);
    check("R9", "reset baud_tick", baud_tick, 0);
    rst = 1'b0; en = 1'b1;
    // R1 reset divisor of 0, R5 tick every cycle
    req = "R5"; st_count = 0; bt_count = 0; step(1); st_count = 0; step(32);
    check("R5", "div0 sample ticks in 32", st_count, 32);
    check("R3", "div0 baud ticks in 32", bt_count, 2);
    // R1 R2 R3 small divisor, 16x
    req = "R2"; write_div(2); st_count = 0; bt_count = 0; step(96);
    check("R2", "div2 sample ticks in 96", st_count, 32);
    check("R3", "div2 baud ticks in 96", bt_count, 2);
    // R7 mode flip mid bit, then R4 4x grouping
    req = "R7"; step(7); fast_mode = 1'b1; step(1);
    check("R7", "no baud after mode flip", baud_tick, 0);
    req = "R4"; step(60);
    fast_mode = 1'b0; req = "R7"; step(50);
    fast_mode = 1'b1; req = "R4"; step(40);
    fast_mode = 1'b0;
    // R6 write in mid period
    req = "R6"; step(5); write_div(48);
    check("R6", "no sample after write", sample_tick, 0);
    step(20); write_div(48);
    // R5 9600-baud example: 784 cycles per bit
    req = "R5"; st_count = 0; bt_count = 0; step(784 * 3);
    check("R5", "div48 baud ticks in 2352", bt_count, 3);
    check("R5", "div48 sample ticks in 2352", st_count, 48);
    // R8 disable window
    write_div(3); step(10);
    req = "R8"; en = 1'b0; st_count = 0; bt_count = 0; step(40);
    check("R8", "ticks while disabled", st_count + bt_count, 0);
    en = 1'b1; req = "R2"; step(80);
    // R9 reset in mid run
    req = "R9"; rst = 1'b1; step(2);
    check("R9", "sample after reset", sample_tick, 0);
    rst = 1'b0; req = "R1"; st_count = 0; step(8);
    check("R1", "divisor back to 0 after reset", st_count, 8);
    // R5 max divisor
    req = "R5"; write_div(65535); st_count = 0; step(65535);
    check("R5", "no tick before 65536 cycles", st_count, 0);
    step(1);
    check("R5", "tick at 65536 cycles", st_count, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule